// File: doc/BRIEF.md
# I2C Register Slave with High-Speed Entry

This block is an I2C target that gives a bus master access to a small bank of control and status registers. SCL and SDA are taken in as plain inputs and oversampled on the system clock. The block pulls the line low through a single pull-down enable output, which the pad turns into an open-drain driver. Only 7-bit addressing is decoded, and the device answers only at the fixed address 0x33.

A write transfer has four parts: a start condition, the address byte with R/W = 0, a pointer byte, and one data byte. The data byte is committed when SCL falls at the end of its acknowledge bit. A read transfer has R/W = 1 and returns the register selected by the last stored pointer, most significant bit first.

If a byte of the form 00001xxx appears in the address slot, it is the high-speed master code. The block never acknowledges this code. It raises a high-speed flag and holds it until the next stop condition, and transfers after a repeated start keep the same framing.

Each register bit is configured by two parameter masks:
- Read-only bits cannot be written. Some of them follow a status input directly.
- Clear-on-read bits latch the status input and return to zero once the register has been read out.

A mirrored mode field means that writing the mode bits of one register also copies them into a field of a second register.

Top module: `i2c_hs_regslave`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal 0x33. Any other value is not acknowledged, including the general-call value 0x00 and the 10-bit prefix 11110xx. After a refused address, the following bytes are neither acknowledged nor acted on until the next start condition.
- R2: An address-slot byte whose upper five bits are 00001 is never acknowledged. It sets `hs_mode_o` high. The flag stays high across repeated starts and the transfers that follow them, and a stop condition clears it.
- R3: For a write, the address byte (LSB 0), the pointer byte and the data byte are each acknowledged. The addressed register changes only on the SCL falling edge that ends the data byte's acknowledge bit. Read-only bits (the whole of register 7 by default) keep their value.
- R4: Only one data byte is stored per write transfer. Any further data byte is not acknowledged and does not change a register.
- R5: For a read (address LSB 1), the block drives the register selected by the stored pointer, MSB first. When the master acknowledges, the same register is sent again. When the master does not acknowledge, SDA is released.
- R6: Clear-on-read bits (bits 3:0 of register 7 by default) are set by a high `status_i` bit and stay set after that bit returns low. They return to zero once the register has been loaded for readout.
- R7: A write to the mode source field (register 1, bits 1:0) also copies that value into the mirror field (register 4, bits 7:6). The other bits of register 4 are left unchanged.
- R8: A start or stop condition in the middle of a byte aborts the transfer and discards the partial byte. A following start condition begins a new address phase.
- R9: A pointer of NUM_REGS or more selects no register. Writes to it are acknowledged but change nothing, and reads from it return 0x00.
- R10: During reset and immediately after it, `sda_pd_o` and `hs_mode_o` are low and the registers hold their reset values (0x5A in register 3, zero elsewhere).
- R11: Read-only bits that are not clear-on-read (bits 7:4 of register 7 by default) follow the matching `status_i` bits a few cycles later, and reading does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| status_i | input | NUM_REGS*8 | Status bits, one byte per register, used only at read-only positions |
| sda_pd_o | output | 1 | When high, the pad pulls SDA low |
| hs_mode_o | output | 1 | High-speed mode flag |
| regs_o | output | NUM_REGS*8 | Register contents, register r at bits r*8+7:r*8 |

## Verification
The block is driven with bus transactions of several shapes:
- Matching and non-matching address bytes, including the general-call and 10-bit values, to separate acknowledge decisions from plain byte reception.
- The high-speed code followed by a repeated start, which shows whether the flag is held until the stop.
- Writes with one data byte, with extra data bytes, to read-only registers and to out-of-range pointers, which separate the storage path from the masks and the single-byte rule.
- A write whose register is observed while SCL is high during the final acknowledge, which pins down the commit edge.
- Reads ending in a master acknowledge and in a master refusal, which expose repeat and release behaviour.
- Status pulses followed by reads, which tell sticky clear-on-read bits apart from live bits.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] HS_CODE_PFX = 5'b00001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_ff[k] <= scl_ff[k-1];
        sda_ff[k] <= sda_ff[k-1];
      end
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  // line events only while SCL stays high over two samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h33
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic [7:0]  rd_data_i,
  output logic        sda_pd_o,
  output logic        hs_mode_o,
  output logic        wr_en_o,
  output logic        rd_en_o,
  output logic [7:0]  ptr_o,
  output logic [7:0]  wdata_o
);
  rs_state_e  state_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q, ptr_q, wbuf_q;
  logic       pd_q, hs_q, rw_q, mack_q;
  logic       load_tx;
  logic       byte_end;

  assign byte_end = scl_fall_i && (cnt_q == 4'd8);
  assign wr_en_o  = (state_q == ST_WDAT_ACK) && scl_fall_i;
  assign load_tx  = scl_fall_i &&
                    (((state_q == ST_ADDR_ACK) && rw_q) || ((state_q == ST_MACK) && mack_q));
  assign rd_en_o  = load_tx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wbuf_q  <= '0;
      pd_q    <= 1'b0;
      hs_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:3] == HS_CODE_PFX) begin
                hs_q    <= 1'b1;
                state_q <= ST_WAIT;
              end else if (sh_q[7:1] == DEV_ADDR) begin
                rw_q    <= sh_q[0];
                pd_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end else if (state_q == ST_PTR) begin
              ptr_q   <= sh_q;
              pd_q    <= 1'b1;
              state_q <= ST_PTR_ACK;
            end else begin
              wbuf_q  <= sh_q;
              pd_q    <= 1'b1;
              state_q <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              pd_q    <= ~rd_data_i[7];
              state_q <= ST_TX;
            end else begin
              pd_q    <= 1'b0;
              state_q <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall_i) begin
            pd_q    <= 1'b0;
            state_q <= ST_WDAT;
          end
        end
        ST_WDAT_ACK: begin
          // one data byte per transfer, later bytes see no acknowledge
          if (scl_fall_i) begin
            pd_q    <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              cnt_q   <= '0;
              pd_q    <= 1'b0;
              mack_q  <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              pd_q <= ~tx_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              tx_q    <= rd_data_i;
              pd_q    <= ~rd_data_i[7];
              state_q <= ST_TX;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pd_o  = pd_q;
  assign hs_mode_o = hs_q;
  assign ptr_o     = ptr_q;
  assign wdata_o   = wbuf_q;
endmodule

// File: rtl/i2c_rs_regbank.sv
module i2c_rs_regbank #(
  parameter int                    NUM_REGS     = 8,
  parameter logic [NUM_REGS*8-1:0] RO_MASK      = '0,
  parameter logic [NUM_REGS*8-1:0] COR_MASK     = '0,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL    = '0,
  parameter bit                    MIRROR_EN    = 1'b1,
  parameter int                    MODE_SRC_REG = 1,
  parameter int                    MODE_SRC_LSB = 0,
  parameter int                    MODE_DST_REG = 4,
  parameter int                    MODE_DST_LSB = 6,
  parameter int                    MODE_W       = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [7:0]              ptr_i,
  input  logic [7:0]              wdata_i,
  input  logic [NUM_REGS*8-1:0]   status_i,
  output logic [7:0]              rd_data_o,
  output logic [NUM_REGS*8-1:0]   regs_o
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic ptr_ok;
  logic mirror_wr;

  assign ptr_ok    = ({24'd0, ptr_i} < NUM_REGS);
  assign mirror_wr = MIRROR_EN && wr_en_i && (ptr_i == 8'(MODE_SRC_REG));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [7:0] RO  = RO_MASK[r*8 +: 8];
    localparam logic [7:0] COR = COR_MASK[r*8 +: 8];
    localparam logic [7:0] RV  = RESET_VAL[r*8 +: 8];

    logic [7:0] q, d, sw, st;
    logic       wr_hit, rd_hit;

    assign wr_hit = wr_en_i && (ptr_i == 8'(r));
    assign rd_hit = rd_en_i && (ptr_i == 8'(r));
    assign st     = status_i[r*8 +: 8];

    always_comb begin
      sw = q;
      if (wr_hit) sw = wdata_i;
      if (mirror_wr && (r == MODE_DST_REG)) sw[MODE_DST_LSB +: MODE_W] = wdata_i[MODE_SRC_LSB +: MODE_W];
      // sticky bits: a set in the same cycle as the clear wins
      d = (sw & ~RO) | (((rd_hit ? 8'h00 : q) | st) & COR) | (st & RO & ~COR);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RV;
      else         q <= d;
    end

    assign regs_o[r*8 +: 8] = q;
  end

  assign rd_data_o = ptr_ok ? regs_o[{ptr_i[PTR_W-1:0], 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/i2c_hs_regslave.sv
module i2c_hs_regslave #(
  parameter logic [6:0]            DEV_ADDR     = 7'h33,
  parameter int                    SYNC_STAGES  = 2,
  parameter int                    NUM_REGS     = 8,
  parameter logic [NUM_REGS*8-1:0] RO_MASK      = 64'hFF00_0000_0000_0000,
  parameter logic [NUM_REGS*8-1:0] COR_MASK     = 64'h0F00_0000_0000_0000,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL    = 64'h0000_0000_5A00_0000,
  parameter bit                    MIRROR_EN    = 1'b1,
  parameter int                    MODE_SRC_REG = 1,
  parameter int                    MODE_SRC_LSB = 0,
  parameter int                    MODE_DST_REG = 4,
  parameter int                    MODE_DST_LSB = 6,
  parameter int                    MODE_W       = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [NUM_REGS*8-1:0] status_i,
  output logic                  sda_pd_o,
  output logic                  hs_mode_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       scl_s_w, sda_s_w, start_w, stop_w, rise_w, fall_w;
  logic       wr_en_w, rd_en_w;
  logic [7:0] ptr_w, wdata_w, rd_data_w;

  i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s_w),
    .sda_o      (sda_s_w),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  i2c_rs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s_w),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .rd_data_i  (rd_data_w),
    .sda_pd_o   (sda_pd_o),
    .hs_mode_o  (hs_mode_o),
    .wr_en_o    (wr_en_w),
    .rd_en_o    (rd_en_w),
    .ptr_o      (ptr_w),
    .wdata_o    (wdata_w)
  );

  i2c_rs_regbank #(
    .NUM_REGS     (NUM_REGS),
    .RO_MASK      (RO_MASK),
    .COR_MASK     (COR_MASK),
    .RESET_VAL    (RESET_VAL),
    .MIRROR_EN    (MIRROR_EN),
    .MODE_SRC_REG (MODE_SRC_REG),
    .MODE_SRC_LSB (MODE_SRC_LSB),
    .MODE_DST_REG (MODE_DST_REG),
    .MODE_DST_LSB (MODE_DST_LSB),
    .MODE_W       (MODE_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_w),
    .rd_en_i   (rd_en_w),
    .ptr_i     (ptr_w),
    .wdata_i   (wdata_w),
    .status_i  (status_i),
    .rd_data_o (rd_data_w),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/i2c_hs_regslave_chk.sv
module i2c_hs_regslave_chk #(
  parameter int                    NUM_REGS     = 8,
  parameter logic [NUM_REGS*8-1:0] COR_MASK     = '0,
  parameter bit                    MIRROR_EN    = 1'b1,
  parameter int                    MODE_SRC_REG = 1,
  parameter int                    MODE_SRC_LSB = 0,
  parameter int                    MODE_DST_REG = 4,
  parameter int                    MODE_DST_LSB = 6,
  parameter int                    MODE_W       = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  scl_fall,
  input logic                  stop,
  input logic                  sda_pd_o,
  input logic                  hs_mode_o,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [7:0]            ptr,
  input logic [7:0]            wdata,
  input logic [NUM_REGS*8-1:0] status_i,
  input logic [NUM_REGS*8-1:0] regs_o
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             rd_q;
  logic [PTR_W-1:0] rp_q;
  logic [7:0]       st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      rp_q <= '0;
      st_q <= '0;
    end else begin
      rd_q <= rd_en && ({24'd0, ptr} < NUM_REGS);
      rp_q <= ptr[PTR_W-1:0];
      st_q <= status_i[{ptr[PTR_W-1:0], 3'b000} +: 8];
    end
  end

  // R5: the slave only starts pulling SDA while SCL is low
  a_r5_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !scl_s);

  // R2
  a_r2_stop_clears_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !hs_mode_o);

  // R3
  a_r3_commit_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> scl_fall);

  // R6: after a readout, only bits set in that cycle remain among the sticky bits
  a_r6_cor_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> ((regs_o[{rp_q, 3'b000} +: 8] & COR_MASK[{rp_q, 3'b000} +: 8]) ==
              (st_q & COR_MASK[{rp_q, 3'b000} +: 8])));

  if (MIRROR_EN) begin : g_mirror
    // R7
    a_r7_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && (ptr == 8'(MODE_SRC_REG))) |=>
      (regs_o[MODE_DST_REG*8 + MODE_DST_LSB +: MODE_W] == $past(wdata[MODE_SRC_LSB +: MODE_W])));
  end
endmodule

bind i2c_hs_regslave i2c_hs_regslave_chk #(
  .NUM_REGS     (NUM_REGS),
  .COR_MASK     (COR_MASK),
  .MIRROR_EN    (MIRROR_EN),
  .MODE_SRC_REG (MODE_SRC_REG),
  .MODE_SRC_LSB (MODE_SRC_LSB),
  .MODE_DST_REG (MODE_DST_REG),
  .MODE_DST_LSB (MODE_DST_LSB),
  .MODE_W       (MODE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s_w),
  .scl_fall  (fall_w),
  .stop      (stop_w),
  .sda_pd_o  (sda_pd_o),
  .hs_mode_o (hs_mode_o),
  .wr_en     (wr_en_w),
  .rd_en     (rd_en_w),
  .ptr       (ptr_w),
  .wdata     (wdata_w),
  .status_i  (status_i),
  .regs_o    (regs_o)
);

// File: tb/i2c_hs_regslave_tb_top.sv
module i2c_hs_regslave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int WDOG       = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [63:0] status_i = '0;
  logic        sda_pd_o, hs_mode_o;
  logic [63:0] regs_o;
  logic        sda_line;
  int          n_chk = 0;
  int          n_bad = 0;

  assign sda_line = m_sda & ~sda_pd_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_hs_regslave dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .status_i  (status_i),
    .sda_pd_o  (sda_pd_o),
    .hs_mode_o (hs_mode_o),
    .regs_o    (regs_o)
  );

  function automatic logic [7:0] rg(input int r);
    return regs_o[r*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_sda = 1'b1; tick(HALF);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(HALF);
      m_scl = 1'b1; tick(HALF);
      m_scl = 1'b0; tick(2);
    end
  endtask

  // returns the line level in the ninth bit: 0 = acknowledged
  task automatic get_ack(output logic ack);
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF/2);
    ack = sda_line;
    tick(HALF - HALF/2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    get_ack(ack);
  endtask

  task automatic get_byte(input logic m_ack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; tick(HALF);
      m_scl = 1'b1; tick(HALF/2);
      d = {d[6:0], sda_line};
      tick(HALF - HALF/2);
      m_scl = 1'b0; tick(2);
    end
    m_sda = ~m_ack; tick(HALF);
    m_scl = 1'b1; tick(HALF);
    m_scl = 1'b0; tick(2);
    m_sda = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    put_byte(8'h66, acks[2]);
    put_byte(p, acks[1]);
    put_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] p, output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    put_byte(8'h66, acks[2]);
    put_byte(p, acks[1]);
    bus_start();
    put_byte(8'h67, acks[0]);
    get_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R10 sda_pd", {63'd0, sda_pd_o}, 64'd0);
    chk("R10 hs", {63'd0, hs_mode_o}, 64'd0);
    chk("R10 regs", regs_o, 64'h0000_0000_5A00_0000);
  endtask

  task automatic t_write_timing();
    logic a0, a1, a2;
    bus_start();
    put_byte(8'h66, a0);
    put_byte(8'h02, a1);
    put_bits(8'hC3, 8);
    m_sda = 1'b1; tick(HALF);
    m_scl = 1'b1; tick(HALF/2);
    a2 = sda_line;
    chk("R3 before commit", {56'd0, rg(2)}, 64'h00);
    tick(HALF - HALF/2);
    m_scl = 1'b0; tick(6);
    chk("R3 after commit", {56'd0, rg(2)}, 64'hC3);
    bus_stop();
    chk("R3 acks", {61'd0, a0, a1, a2}, 64'd0);
  endtask

  task automatic t_read_only();
    logic [2:0] a;
    wr_reg(8'h07, 8'hFF, a);
    chk("R3 ro acks", {61'd0, a}, 64'd0);
    chk("R3 ro reg7", {56'd0, rg(7)}, 64'h00);
  endtask

  task automatic t_addr_nack();
    logic a;
    logic [2:0] aa;
    bus_start(); put_byte(8'h64, a); bus_stop();
    chk("R1 wrong addr", {63'd0, a}, 64'd1);
    bus_start(); put_byte(8'h00, a);
    chk("R1 general call", {63'd0, a}, 64'd1);
    put_byte(8'h02, a);
    chk("R1 follow byte", {63'd0, a}, 64'd1);
    put_byte(8'h11, a);
    bus_stop();
    chk("R1 no write", {56'd0, rg(2)}, 64'hC3);
    bus_start(); put_byte(8'hF0, a); bus_stop();
    chk("R1 ten-bit prefix", {63'd0, a}, 64'd1);
    wr_reg(8'h02, 8'h11, aa);
    chk("R1 match acks", {61'd0, aa}, 64'd0);
    chk("R1 match write", {56'd0, rg(2)}, 64'h11);
  endtask

  task automatic t_hs();
    logic a, b, c, d;
    bus_start();
    put_byte(8'h0B, a);
    chk("R2 code nack", {63'd0, a}, 64'd1);
    chk("R2 flag set", {63'd0, hs_mode_o}, 64'd1);
    bus_start();
    put_byte(8'h66, b); put_byte(8'h01, c); put_byte(8'h02, d);
    chk("R2 hs acks", {61'd0, b, c, d}, 64'd0);
    chk("R2 flag held", {63'd0, hs_mode_o}, 64'd1);
    bus_stop();
    chk("R2 flag cleared", {63'd0, hs_mode_o}, 64'd0);
    chk("R2 reg1", {56'd0, rg(1)}, 64'h02);
    chk("R7 mirror first", {56'd0, rg(4)}, 64'h80);
  endtask

  task automatic t_mirror();
    logic [2:0] a;
    wr_reg(8'h04, 8'h15, a);
    chk("R7 direct", {56'd0, rg(4)}, 64'h15);
    wr_reg(8'h01, 8'h03, a);
    chk("R7 src", {56'd0, rg(1)}, 64'h03);
    chk("R7 dst merged", {56'd0, rg(4)}, 64'hD5);
  endtask

  task automatic t_extra();
    logic a0, a1, a2, a3;
    bus_start();
    put_byte(8'h66, a0); put_byte(8'h02, a1); put_byte(8'h3C, a2); put_byte(8'h77, a3);
    bus_stop();
    chk("R4 first acks", {61'd0, a0, a1, a2}, 64'd0);
    chk("R4 extra nack", {63'd0, a3}, 64'd1);
    chk("R4 reg2", {56'd0, rg(2)}, 64'h3C);
  endtask

  task automatic t_read();
    logic a0, a1, a2;
    logic [7:0] d0, d1;
    logic [2:0] aa;
    bus_start();
    put_byte(8'h66, a0); put_byte(8'h02, a1);
    bus_start();
    put_byte(8'h67, a2);
    get_byte(1'b1, d0);
    get_byte(1'b0, d1);
    tick(4);
    chk("R5 released", {63'd0, sda_pd_o}, 64'd0);
    bus_stop();
    chk("R5 acks", {61'd0, a0, a1, a2}, 64'd0);
    chk("R5 first", {56'd0, d0}, 64'h3C);
    chk("R5 repeat", {56'd0, d1}, 64'h3C);
    rd_reg(8'h03, d0, aa);
    chk("R5 reg3", {56'd0, d0}, 64'h5A);
  endtask

  task automatic t_cor();
    logic [7:0] d;
    logic [2:0] aa;
    status_i[63:56] = 8'h05; tick(3);
    status_i[63:56] = 8'h00; tick(3);
    chk("R6 sticky", {56'd0, rg(7)}, 64'h05);
    status_i[63:56] = 8'h10; tick(4);
    chk("R11 live on", {56'd0, rg(7)}, 64'h15);
    rd_reg(8'h07, d, aa);
    chk("R6 read value", {56'd0, d}, 64'h15);
    chk("R6 cleared", {56'd0, rg(7)}, 64'h10);
    status_i[63:56] = 8'h00; tick(4);
    chk("R11 live off", {56'd0, rg(7)}, 64'h00);
  endtask

  task automatic t_abort();
    logic a0, a1;
    logic [2:0] aa;
    bus_start();
    put_byte(8'h66, a0); put_byte(8'h02, a1);
    put_bits(8'hFF, 4);
    bus_stop();
    chk("R8 stop abort", {56'd0, rg(2)}, 64'h3C);
    chk("R8 pd idle", {63'd0, sda_pd_o}, 64'd0);
    bus_start();
    put_bits(8'h60, 3);
    bus_start();
    put_byte(8'h66, aa[2]); put_byte(8'h02, aa[1]); put_byte(8'h5E, aa[0]);
    bus_stop();
    chk("R8 restart acks", {61'd0, aa}, 64'd0);
    chk("R8 restart write", {56'd0, rg(2)}, 64'h5E);
  endtask

  task automatic t_range();
    logic [63:0] snap;
    logic [7:0] d;
    logic [2:0] aa;
    snap = regs_o;
    wr_reg(8'h20, 8'hAA, aa);
    chk("R9 acks", {61'd0, aa}, 64'd0);
    chk("R9 no change", regs_o, snap);
    rd_reg(8'h20, d, aa);
    chk("R9 read zero", {56'd0, d}, 64'h00);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_ni = 1'b1;
    tick(5);
    t_reset();
    t_write_timing();
    t_read_only();
    t_addr_nack();
    t_hs();
    t_mirror();
    t_extra();
    t_read();
    t_cor();
    t_abort();
    t_range();
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule